// File: doc/BRIEF.md
# Pattern Table Interference Monitor

This block watches the update stream of a global-history branch predictor whose pattern table holds 2-bit saturating counters. For each update it receives the branch PC, the 16-bit global history in use, and the counter state before and after the write. The predictor's own table and its fetch-path use are outside this block. The block only decides whether the update was destructive interference and keeps statistics on it.

An update is interference when it changes the counter's state and its PC differs from the PC that last changed the same entry. Interference events are counted in seventeen bins. The bin is chosen by how many taken bits (ones) the history holds. A separate counter records every update, so that software can work out what fraction of updates interfere.

The monitor rebuilds the table index itself, and an input selects how. It uses either the history alone, or the history XORed with the branch PC, as a hashed index would. It keeps a small record of the last changing PC for each entry. All counters can be read by address.

Top module: `pht_intf_monitor`

## Requirements
- R1: The entry index is the low IDX_W bits of `upd_hist` when `mode` is 0, and the low IDX_W bits of (`upd_hist` XOR `upd_pc[15:0]`) when `mode` is 1.
- R2: An update with `upd_old` equal to `upd_new` is never counted as interference.
- R3: A state-changing update is counted as interference only if its entry already has a recorded last changer and that PC differs from `upd_pc`. The first change to an entry after reset is not counted.
- R4: The recorded last changer of an entry is written only by state-changing updates. A non-changing update leaves it unchanged.
- R5: An interference event increments the bin whose number equals the count of ones in `upd_hist` (0 to 16). Bin n is read at `rd_addr` = n.
- R6: Bin counters stop at 2^BIN_W-1 and the update counter stops at 2^TOT_W-1. Neither wraps.
- R7: While `clr` is high at a clock edge, all bins and the update counter become zero and that cycle's update is not counted. The last-changer record is kept and still updated.
- R8: The update counter, read at `rd_addr` = 17, increments once for every cycle with `upd_valid` high. Addresses 18 to 31 read zero. Reads are combinational.
- R9: After reset, every counter reads zero and no entry has a recorded last changer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Zero all statistics counters |
| mode | input | 1 | Index scheme: 0 history, 1 history XOR PC |
| upd_valid | input | 1 | A pattern-table update is presented this cycle |
| upd_pc | input | PC_W | PC of the updating branch |
| upd_hist | input | 16 | Global history used for the update |
| upd_old | input | 2 | Counter state before the update |
| upd_new | input | 2 | Counter state after the update |
| rd_addr | input | 5 | Counter select for reading |
| rd_data | output | TOT_W | Selected counter value, zero-extended |

## Verification
The assertions check the following on every cycle:
- an interference flag only appears with a valid update that changes the state;
- the update counter steps by exactly one per update, holds when idle, stays at its ceiling, and drops to zero after a clear.

Some behaviours need a bench scenario to show, because they depend on history across many cycles:
- whether an event is counted depends on the recorded last changer of the entry;
- under the XOR mode, a different history can alias onto an entry;
- the bin must match the popcount of the history;
- a clear must keep the owner record.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
    localparam int HIST_W    = 16;
    localparam int CTR_W     = 2;
    localparam int NUM_BINS  = HIST_W + 1;
    localparam int BIN_IDX_W = $clog2(NUM_BINS);
    localparam int TOTAL_ADDR = NUM_BINS;
    localparam int RD_AW     = $clog2(NUM_BINS + 1);

    typedef enum logic {
        IDX_HIST     = 1'b0,
        IDX_HIST_XOR = 1'b1
    } idx_mode_e;

    typedef struct packed {
        logic                 valid;
        logic                 interfere;
        logic [BIN_IDX_W-1:0] bin;
    } pmon_evt_t;

    function automatic logic [BIN_IDX_W-1:0] ones_in(input logic [HIST_W-1:0] h);
        logic [BIN_IDX_W-1:0] n;
        n = '0;
        for (int i = 0; i < HIST_W; i++) begin
            n = n + BIN_IDX_W'(h[i]);
        end
        return n;
    endfunction
endpackage

// File: rtl/pmon_index.sv
module pmon_index
    import pmon_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6
) (
    input  idx_mode_e          mode,
    input  logic [PC_W-1:0]    pc,
    input  logic [HIST_W-1:0]  hist,
    output logic [IDX_W-1:0]   idx
);
    logic [HIST_W-1:0] folded;

    generate
        if (IDX_W > HIST_W) begin : g_bad_width
            initial $error("pmon_index: IDX_W exceeds history width");
        end
    endgenerate

    always_comb begin
        unique case (mode)
            IDX_HIST_XOR: folded = hist ^ pc[HIST_W-1:0];
            default:      folded = hist;
        endcase
        idx = folded[IDX_W-1:0];
    end
endmodule

// File: rtl/pmon_owner.sv
module pmon_owner #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_valid,
    input  logic             changed,
    input  logic [IDX_W-1:0] idx,
    input  logic [PC_W-1:0]  pc,
    output logic             interfere
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] own_v;
    logic [PC_W-1:0]  own_pc [DEPTH];
    logic             write_en;

    assign write_en  = upd_valid && changed;
    assign interfere = write_en && own_v[idx] && (own_pc[idx] != pc);

    always_ff @(posedge clk) begin
        if (rst) begin
            own_v <= '0;
        end else if (write_en) begin
            own_v[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (write_en) begin
            own_pc[idx] <= pc;
        end
    end
endmodule

// File: rtl/pmon_counters.sv
module pmon_counters
    import pmon_pkg::*;
#(
    parameter int BIN_W = 16,
    parameter int TOT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  pmon_evt_t        evt,
    input  logic [RD_AW-1:0] rd_addr,
    output logic [TOT_W-1:0] rd_data,
    output logic [TOT_W-1:0] total
);
    localparam logic [BIN_W-1:0] BIN_MAX = '1;
    localparam logic [TOT_W-1:0] TOT_MAX = '1;

    logic [BIN_W-1:0] bin_q [NUM_BINS];
    logic [TOT_W-1:0] tot_q;

    generate
        for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    bin_q[b] <= '0;
                end else if (evt.valid && evt.interfere &&
                             evt.bin == BIN_IDX_W'(b) && bin_q[b] != BIN_MAX) begin
                    bin_q[b] <= bin_q[b] + 1'b1;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tot_q <= '0;
        end else if (evt.valid && tot_q != TOT_MAX) begin
            tot_q <= tot_q + 1'b1;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NUM_BINS; b++) begin
            if (rd_addr == RD_AW'(b)) begin
                rd_data = TOT_W'(bin_q[b]);
            end
        end
        if (rd_addr == RD_AW'(TOTAL_ADDR)) begin
            rd_data = tot_q;
        end
    end

    assign total = tot_q;
endmodule

// File: rtl/pht_intf_monitor.sv
module pht_intf_monitor
    import pmon_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6,
    parameter int BIN_W = 16,
    parameter int TOT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              mode,
    input  logic              upd_valid,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic [HIST_W-1:0] upd_hist,
    input  logic [CTR_W-1:0]  upd_old,
    input  logic [CTR_W-1:0]  upd_new,
    input  logic [RD_AW-1:0]  rd_addr,
    output logic [TOT_W-1:0]  rd_data
);
    logic [IDX_W-1:0] entry_idx;
    logic             evt_interfere;
    logic [TOT_W-1:0] total_cnt;
    pmon_evt_t        evt;

    pmon_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_index (
        .mode (idx_mode_e'(mode)),
        .pc   (upd_pc),
        .hist (upd_hist),
        .idx  (entry_idx)
    );

    pmon_owner #(.PC_W(PC_W), .IDX_W(IDX_W)) u_owner (
        .clk       (clk),
        .rst       (rst),
        .upd_valid (upd_valid),
        .changed   (upd_old != upd_new),
        .idx       (entry_idx),
        .pc        (upd_pc),
        .interfere (evt_interfere)
    );

    always_comb begin
        evt.valid     = upd_valid;
        evt.interfere = evt_interfere;
        evt.bin       = ones_in(upd_hist);
    end

    pmon_counters #(.BIN_W(BIN_W), .TOT_W(TOT_W)) u_counters (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .evt     (evt),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .total   (total_cnt)
    );
endmodule

// File: rtl/pmon_checker.sv
module pmon_checker #(
    parameter int TOT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             upd_valid,
    input logic [1:0]       upd_old,
    input logic [1:0]       upd_new,
    input logic             interfere,
    input logic [TOT_W-1:0] total
);
    localparam logic [TOT_W-1:0] TOT_MAX = '1;

    assert_no_change_no_intf_R2: assert property (@(posedge clk) disable iff (rst)
        interfere |-> (upd_valid && upd_old != upd_new));

    assert_total_step_R8: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !clr && total != TOT_MAX) |=> total == $past(total) + 1'b1);

    assert_total_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!upd_valid && !clr) |=> $stable(total));

    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (rst)
        clr |=> total == '0);

    assert_total_sat_R6: assert property (@(posedge clk) disable iff (rst)
        (!clr && total == TOT_MAX) |=> total == TOT_MAX);
endmodule

bind pht_intf_monitor pmon_checker #(.TOT_W(TOT_W)) u_pmon_checker (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .upd_valid (upd_valid),
    .upd_old   (upd_old),
    .upd_new   (upd_new),
    .interfere (evt_interfere),
    .total     (total_cnt)
);

// File: tb/pht_intf_monitor_bench.sv
`timescale 1ns/1ps
module pht_intf_monitor_bench;
    localparam int PC_W  = 32;
    localparam int IDX_W = 6;
    localparam int BIN_W = 6;
    localparam int TOT_W = 32;
    localparam int DEPTH = 1 << IDX_W;
    localparam int BIN_MAX = (1 << BIN_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              clr = 1'b0;
    logic              mode = 1'b0;
    logic              upd_valid = 1'b0;
    logic [PC_W-1:0]   upd_pc = '0;
    logic [15:0]       upd_hist = '0;
    logic [1:0]        upd_old = '0;
    logic [1:0]        upd_new = '0;
    logic [4:0]        rd_addr = '0;
    logic [TOT_W-1:0]  rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit              m_v  [DEPTH];
    logic [PC_W-1:0] m_pc [DEPTH];
    int unsigned     m_bin [17];
    int unsigned     m_tot;

    always #2 clk = ~clk;

    pht_intf_monitor #(.PC_W(PC_W), .IDX_W(IDX_W), .BIN_W(BIN_W), .TOT_W(TOT_W))
    u_pht_intf_monitor (
        .clk(clk), .rst(rst), .clr(clr), .mode(mode), .upd_valid(upd_valid),
        .upd_pc(upd_pc), .upd_hist(upd_hist), .upd_old(upd_old), .upd_new(upd_new),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic int exp_idx(input logic m, input logic [PC_W-1:0] pc,
                                   input logic [15:0] h);
        logic [15:0] f;
        f = m ? (h ^ pc[15:0]) : h;
        return int'(f[IDX_W-1:0]);
    endfunction

    task automatic chk(input string req, input logic [TOT_W-1:0] act,
                       input logic [TOT_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr=%0d actual=%0d expected=%0d", req, rd_addr, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
        for (int b = 0; b < 17; b++) m_bin[b] = 0;
        m_tot = 0;
    endtask

    task automatic upd(input logic m, input logic [PC_W-1:0] pc, input logic [15:0] h,
                       input logic [1:0] o, input logic [1:0] n, input logic c);
        int  i;
        bit  chg, intf;
        @(negedge clk);
        mode = m; upd_pc = pc; upd_hist = h; upd_old = o; upd_new = n;
        clr = c; upd_valid = 1'b1;
        @(posedge clk);
        i    = exp_idx(m, pc, h);
        chg  = (o != n);
        intf = chg && m_v[i] && (m_pc[i] != pc);
        if (c) begin
            for (int b = 0; b < 17; b++) m_bin[b] = 0;
            m_tot = 0;
        end else begin
            m_tot++;
            if (intf && m_bin[$countones(h)] < BIN_MAX) m_bin[$countones(h)]++;
        end
        if (chg) begin
            m_v[i] = 1; m_pc[i] = pc;
        end
        #1;
        upd_valid = 1'b0; clr = 1'b0;
    endtask

    task automatic readout(input string req);
        @(negedge clk);
        for (int a = 0; a < 18; a++) begin
            rd_addr = 5'(a);
            #0.2;
            chk(req, rd_data, (a < 17) ? TOT_W'(m_bin[a]) : TOT_W'(m_tot));
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R9: everything zero after reset
        readout("R9");

        // R3: first change on an entry is not counted; same PC again not counted
        upd(0, 32'h100, 16'h0007, 2'd1, 2'd2, 0);
        upd(0, 32'h100, 16'h0007, 2'd2, 2'd3, 0);
        readout("R3");
        // R3/R5: a different PC changing it is counted in bin 3
        upd(0, 32'h204, 16'h0007, 2'd3, 2'd2, 0);
        readout("R5");

        // R2: no state change from another PC is not counted, total still counts (R8)
        upd(0, 32'h308, 16'h0007, 2'd2, 2'd2, 0);
        readout("R2");
        // R4: owner must still be 0x204, so this change by 0x204 is not counted
        upd(0, 32'h204, 16'h0007, 2'd2, 2'd1, 0);
        readout("R4");

        // R1: mode 0 sets owner at entry 0x05; mode 1 aliases another history onto it
        upd(0, 32'h400, 16'h0005, 2'd0, 2'd1, 0);
        upd(1, 32'h0000_0030, 16'h0035, 2'd1, 2'd2, 0);
        readout("R1");
        // R1: in mode 0 the same history/PC lands on entry 0x35, first change there
        upd(0, 32'h0000_0031, 16'h0035, 2'd1, 2'd0, 0);
        readout("R1");

        // R6: saturate bin 16 with alternating changers on history 0xFFFF
        for (int k = 0; k < BIN_MAX + 8; k++) begin
            upd(0, (k % 2) ? 32'hA0 : 32'hB0, 16'hFFFF, 2'(k), 2'(k + 1), 0);
        end
        readout("R6");

        // R7: clear with a simultaneous interfering update wipes all counters
        upd(0, 32'hC0, 16'hFFFF, 2'd0, 2'd3, 1);
        readout("R7");
        // R7: owner record kept (0xC0), so 0xA0 changing it is counted at once
        upd(0, 32'hA0, 16'hFFFF, 2'd3, 2'd0, 0);
        readout("R7");

        // R8: unmapped addresses read zero
        @(negedge clk);
        rd_addr = 5'd18; #0.2; chk("R8", rd_data, '0);
        rd_addr = 5'd31; #0.2; chk("R8", rd_data, '0);

        // Random mix across both modes and history densities (R1 R3 R5 R8)
        for (int blk = 0; blk < 30; blk++) begin
            logic m;
            m = 1'(blk % 2);
            for (int k = 0; k < 100; k++) begin
                logic [15:0] h;
                int sel;
                sel = $urandom % 3;
                if (sel == 0) h = 16'($urandom);
                else if (sel == 1) h = 16'($urandom & $urandom & $urandom);
                else h = 16'($urandom | $urandom);
                upd(m, 32'h1000 + 32'(($urandom % 4) * 4), h,
                    2'($urandom), 2'($urandom), ($urandom % 97) == 0);
            end
            readout("R5");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule